// File: doc/BRIEF.md
# Shared-Bus Converter Poll Controller

This block is the host side of an SPI bus shared by several data converters. Clock, host-out data and the combined data-out/ready line are common to all converters. Each converter has its own active-low select, and no converter has a separate ready wire. The controller finds new conversions by briefly selecting each converter and looking at the shared line. A deselected converter leaves that line floating, so its readiness can only be seen while it is selected.

The converters are visited in a fixed rotation. After a converter is selected, the line is sampled one clock later. High means nothing is pending, and the slot ends with no serial clock pulses. Low means a result is waiting. The controller then runs a 16-bit read, MSB first, in SPI mode 1: the clock idles low, the converter changes data on the rising edge and the host samples on the falling edge. A trailer of 16 more clocks with host-out data held low follows the read. During that trailer the converter's line goes low for 8 clocks and then high, so the line is left high before the select is released. Each result appears for one cycle on a valid/channel/data output. Between accesses all selects stay high for a minimum number of cycles.

Top module: `cvt_poll_ctrl`

## Requirements
- R1: While reset is asserted and just after it, every select is high (1), the serial clock is low, busy is low, and neither res_valid nor trail_err is asserted.
- R2: At most one select is low at any time. Converters are visited in index order 0, 1, ..., N_SLV-1, then 0 again, starting from index 0 after reset. The index advances by one after every slot, whether or not data was read.
- R3: The shared line is sampled on the clock edge one cycle after a select falls. If it is high (1), no serial clock pulse is issued and the select rises at that same edge.
- R4: If the sampled line is low (0), the select stays low for DATA_W + TRAIL_CLKS serial clock periods. Each half period lasts half_div+1 system cycles, and the first half period of each clock is low. The serial clock is low whenever no select is low.
- R5: The line is sampled at each falling edge of the serial clock. The first DATA_W samples, MSB first, form the result. On the edge of the DATA_W-th falling sample, res_valid pulses for exactly one cycle with res_chan set to the converter index and res_data set to the result.
- R6: The host-out data line is held low at all times, including the whole trailer.
- R7: The select rises on the edge of the last trailer falling sample. If the line is low (0) at that sample, trail_err pulses for one cycle together with the select rising.
- R8: After any access, every select stays high for at least CS_GAP system cycles before the next select falls.
- R9: enable is sampled while idle and at the end of each inter-access gap. If it is high, the next converter in rotation is selected on that edge; if low, the controller goes idle. A slot already under way always runs to completion.
- R10: busy is high from the edge that starts a slot until the edge that returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Allow polling to continue |
| half_div | input | DIV_W | Serial clock half period minus one, in system cycles |
| rdy_miso | input | 1 | Shared converter data-out / ready line |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Host-out data, held low |
| cs_n | output | N_SLV | Active-low select, one per converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | IDX_W | Converter index of the result |
| res_data | output | DATA_W | Result word |
| trail_err | output | 1 | Line was low at the last trailer sample |
| busy | output | 1 | Controller is not idle |

## Verification
The properties assume the system reset is clean and that half_div does not change while busy is high. The bench only changes half_div while the controller is idle. The properties also assume the shared line is driven by a converter that follows the select and the serial clock. The bench meets this with a converter model that changes its bit one half period before each host sample: it drives the ready level from the moment it is selected, and it drives data and trailer bits only on rising clocks. Pending results and trailer faults are loaded only while enable is low and the controller is idle, so no converter's state changes in the middle of its own access.

// File: rtl/cvt_poll_pkg.sv
package cvt_poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEL   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } poll_st_e;

endpackage

// File: rtl/cvt_poll_sclk.sv
module cvt_poll_sclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             wrap;

  assign wrap = (cnt_q == half_div);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // the edge that ends a high half period is a falling one
  assign fall_tick = run && wrap && sclk_q;
  assign sclk      = sclk_q;

endmodule

// File: rtl/cvt_poll_rr.sv
module cvt_poll_rr #(
  parameter int N_SLV = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_nxt,
  output logic [N_SLV-1:0] sel_oh_nxt
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLV - 1);

  logic [IDX_W-1:0] idx_q;

  always_comb begin
    idx_nxt = idx_q;
    if (advance) begin
      idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= idx_nxt;
    end
  end

  for (genvar g = 0; g < N_SLV; g++) begin : g_dec
    assign sel_oh_nxt[g] = (idx_nxt == IDX_W'(g));
  end

  assign idx = idx_q;

endmodule

// File: rtl/cvt_poll_rx.sv
module cvt_poll_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [DATA_W-1:0] word_nxt
);

  logic [DATA_W-1:0] sr_q;

  assign word_nxt = {sr_q[DATA_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= word_nxt;
    end
  end

endmodule

// File: rtl/cvt_poll_ctrl.sv
module cvt_poll_ctrl #(
  parameter  int N_SLV      = 4,
  parameter  int DATA_W     = 16,
  parameter  int TRAIL_CLKS = 16,
  parameter  int CS_GAP     = 3,
  parameter  int DIV_W      = 8,
  localparam int IDX_W      = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              rdy_miso,
  output logic              sclk,
  output logic              mosi,
  output logic [N_SLV-1:0]  cs_n,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              trail_err,
  output logic              busy
);

  import cvt_poll_pkg::*;

  localparam int TOT   = DATA_W + TRAIL_CLKS;
  localparam int BIT_W = $clog2(TOT);
  localparam int GAP_W = $clog2(CS_GAP + 1);

  localparam logic [BIT_W-1:0] BIT_LAST_DATA = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] BIT_LAST_ALL  = BIT_W'(TOT - 1);
  localparam logic [GAP_W-1:0] GAP_LAST      = GAP_W'(CS_GAP - 1);

  // reset: asserted at once, released after two clocks
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  poll_st_e          st_q, st_d;
  logic [BIT_W-1:0]  bitn_q, bitn_d;
  logic [GAP_W-1:0]  gcnt_q, gcnt_d;
  logic [N_SLV-1:0]  cs_n_q, cs_n_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;
  logic [IDX_W-1:0]  chan_q, chan_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic              run, fall_tick, advance;
  logic [IDX_W-1:0]  idx, idx_nxt;
  logic [N_SLV-1:0]  sel_oh_nxt;
  logic [DATA_W-1:0] word_nxt;
  logic              data_phase, last_data, last_trail;

  assign run        = (st_q == ST_SHIFT);
  assign data_phase = run && fall_tick && (bitn_q < BIT_W'(DATA_W));
  assign last_data  = run && fall_tick && (bitn_q == BIT_LAST_DATA);
  assign last_trail = run && fall_tick && (bitn_q == BIT_LAST_ALL);
  assign advance    = (st_q == ST_GAP) && (gcnt_q == GAP_LAST);

  cvt_poll_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk       (clk),
    .rst_n     (rs_q),
    .run       (run),
    .half_div  (half_div),
    .sclk      (sclk),
    .fall_tick (fall_tick)
  );

  cvt_poll_rr #(.N_SLV(N_SLV), .IDX_W(IDX_W)) u_rr (
    .clk        (clk),
    .rst_n      (rs_q),
    .advance    (advance),
    .idx        (idx),
    .idx_nxt    (idx_nxt),
    .sel_oh_nxt (sel_oh_nxt)
  );

  cvt_poll_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rs_q),
    .shift_en (data_phase),
    .din      (rdy_miso),
    .word_nxt (word_nxt)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    bitn_d = bitn_q;
    gcnt_d = '0;
    case (st_q)
      ST_IDLE: begin
        if (enable) st_d = ST_SEL;
      end
      ST_SEL: begin
        bitn_d = '0;
        st_d   = rdy_miso ? ST_GAP : ST_SHIFT;
      end
      ST_SHIFT: begin
        if (fall_tick) begin
          bitn_d = bitn_q + 1'b1;
          if (bitn_q == BIT_LAST_ALL) st_d = ST_GAP;
        end
      end
      ST_GAP: begin
        gcnt_d = gcnt_q + 1'b1;
        if (advance) st_d = enable ? ST_SEL : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cs_n_d = '1;
    if ((st_d == ST_SEL) || (st_d == ST_SHIFT)) cs_n_d = ~sel_oh_nxt;
    vld_d  = last_data;
    err_d  = last_trail && !rdy_miso;
    chan_d = chan_q;
    data_d = data_q;
    if (last_data) begin
      chan_d = idx;
      data_d = word_nxt;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      st_q   <= ST_IDLE;
      bitn_q <= '0;
      gcnt_q <= '0;
      cs_n_q <= '1;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      chan_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      bitn_q <= bitn_d;
      gcnt_q <= gcnt_d;
      cs_n_q <= cs_n_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
      chan_q <= chan_d;
      data_q <= data_d;
    end
  end

  assign cs_n      = cs_n_q;
  assign mosi      = 1'b0;
  assign res_valid = vld_q;
  assign res_chan  = chan_q;
  assign res_data  = data_q;
  assign trail_err = err_q;
  assign busy      = (st_q != ST_IDLE);

endmodule

// File: rtl/cvt_poll_chk.sv
module cvt_poll_chk #(
  parameter int N_SLV  = 4,
  parameter int CS_GAP = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SLV-1:0] cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             res_valid,
  input logic             trail_err,
  input logic             busy
);

  localparam int HW = $clog2(CS_GAP + 2);

  logic          all_hi;
  logic          prev_hi_q;
  logic [HW-1:0] hi_cnt_q;

  assign all_hi = &cs_n;

  // counts cycles every select has been high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi_q <= 1'b1;
      hi_cnt_q  <= HW'(CS_GAP);
    end else begin
      prev_hi_q <= all_hi;
      if (!all_hi)                    hi_cnt_q <= '0;
      else if (hi_cnt_q < HW'(CS_GAP)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_sclk_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !all_hi);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_valid_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !all_hi);

  p_mosi_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mosi);

  p_err_after_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trail_err |-> ($past(sclk) && all_hi));

  p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_hi_q && !all_hi) |-> (hi_cnt_q >= HW'(CS_GAP)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (all_hi && !sclk));

endmodule

bind cvt_poll_ctrl cvt_poll_chk #(.N_SLV(N_SLV), .CS_GAP(CS_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .res_valid (res_valid),
  .trail_err (trail_err),
  .busy      (busy)
);

// File: tb/tb_cvt_poll_ctrl.sv
module tb_cvt_poll_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int DW     = 16;
  localparam int GAP    = 3;
  localparam int TRAIL  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic [7:0]    half_div;
  logic          rdy_miso;
  logic          sclk, mosi, res_valid, trail_err, busy;
  logic [N-1:0]  cs_n;
  logic [1:0]    res_chan;
  logic [DW-1:0] res_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int n_valid = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_poll_ctrl #(.N_SLV(N), .DATA_W(DW), .TRAIL_CLKS(TRAIL), .CS_GAP(GAP),
                  .DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .rdy_miso(rdy_miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .trail_err(trail_err), .busy(busy));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- converter models on the shared bus ----------------
  logic [DW-1:0] sval  [N];
  int            pend  [N];
  int            took  [N];
  bit            sfault[N];
  int            rcnt;
  int            cur;
  logic          sbit;
  logic          sclk_last;

  function automatic int sel_of(input logic [N-1:0] c);
    int r = 0;
    for (int i = 0; i < N; i++) if (!c[i]) r = i;
    return r;
  endfunction

  assign rdy_miso = (&cs_n) ? 1'b1 :
                    (rcnt == 0) ? !(pend[sel_of(cs_n)] > took[sel_of(cs_n)]) : sbit;

  initial begin
    for (int i = 0; i < N; i++) begin
      took[i] = 0;
    end
    rcnt = 0; cur = 0; sbit = 1'b1; sclk_last = 1'b0;
  end

  always @(negedge clk) begin
    if (&cs_n) begin
      if (rcnt >= DW) took[cur] <= took[cur] + 1;
      rcnt <= 0;
    end else begin
      cur <= sel_of(cs_n);
      if (sclk && !sclk_last) begin
        rcnt <= rcnt + 1;
        if (rcnt + 1 <= DW)          sbit <= sval[sel_of(cs_n)][DW - 1 - rcnt];
        else if (rcnt + 1 <= DW + 8) sbit <= 1'b0;
        else                         sbit <= !sfault[sel_of(cs_n)];
      end
    end
    sclk_last <= sclk;
  end

  // ---------------- behavioural cycle reference ----------------
  logic [N-1:0]  exp_cs;
  logic          exp_sclk, exp_busy, exp_valid, exp_err;
  int            exp_chan;
  logic [DW-1:0] exp_data;
  int            m_idx;
  bit            model_on = 1'b0;

  task automatic adv();
    @(posedge clk);
    exp_valid = 1'b0;
    exp_err   = 1'b0;
  endtask

  task automatic slot(output bit again);
    logic [DW-1:0] acc;
    logic m;
    int hd;
    acc = '0;
    hd  = half_div;
    adv();
    if (rdy_miso === 1'b0) begin
      for (int b = 0; b < DW + TRAIL; b++) begin
        repeat (hd) adv();
        adv();
        exp_sclk = 1'b1;
        repeat (hd) adv();
        adv();
        m = rdy_miso;
        exp_sclk = 1'b0;
        if (b < DW) acc = {acc[DW-2:0], m};
        if (b == DW - 1) begin
          exp_valid = 1'b1;
          exp_chan  = m_idx;
          exp_data  = acc;
        end
        if (b == DW + TRAIL - 1) begin
          exp_err = !m;
          exp_cs  = '1;
        end
      end
    end else begin
      exp_cs = '1;
    end
    repeat (GAP - 1) adv();
    adv();
    m_idx = (m_idx + 1) % N;
    if (enable) begin
      exp_cs = ~(N'(1) << m_idx);
      again  = 1'b1;
    end else begin
      exp_busy = 1'b0;
      again    = 1'b0;
    end
  endtask

  initial begin
    bit again;
    exp_cs = '1; exp_sclk = 1'b0; exp_busy = 1'b0;
    exp_valid = 1'b0; exp_err = 1'b0; exp_chan = 0; exp_data = '0;
    m_idx = 0;
    @(posedge rst_n);
    model_on = 1'b1;
    forever begin
      do adv(); while (!enable);
      exp_busy = 1'b1;
      exp_cs   = ~(N'(1) << m_idx);
      do slot(again); while (again);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      chk(cs_n === exp_cs, "R2", "cs_n", 32'(cs_n), 32'(exp_cs));
      chk(sclk === exp_sclk, "R4", "sclk", 32'(sclk), 32'(exp_sclk));
      chk(busy === exp_busy, "R10", "busy", 32'(busy), 32'(exp_busy));
      chk(mosi === 1'b0, "R6", "mosi", 32'(mosi), 0);
      chk(res_valid === exp_valid, "R5", "res_valid", 32'(res_valid), 32'(exp_valid));
      chk(trail_err === exp_err, "R7", "trail_err", 32'(trail_err), 32'(exp_err));
      if (exp_valid && res_valid) begin
        chk(res_chan == 2'(exp_chan), "R5", "res_chan", 32'(res_chan), 32'(exp_chan));
        chk(res_data === exp_data, "R5", "res_data", 32'(res_data), 32'(exp_data));
        // MSB-first result must equal what the converter holds
        chk(res_data === sval[res_chan], "R5", "word vs converter",
            32'(res_data), 32'(sval[res_chan]));
      end
      if (res_valid) n_valid++;
      if (trail_err) n_err++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    int lim = 0;
    @(negedge clk);
    while (busy && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
  endtask

  task automatic wait_drained();
    int lim = 0;
    bit left = 1'b1;
    while (left && lim < 20000) begin
      @(negedge clk);
      lim++;
      left = 1'b0;
      for (int i = 0; i < N; i++) if (pend[i] > took[i]) left = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      pend[i] = 0; sval[i] = '0; sfault[i] = 1'b0;
    end
    rst_n = 1'b0; enable = 1'b0; half_div = 8'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n === '1, "R1", "cs_n in reset", 32'(cs_n), 32'hF);
    chk(sclk === 1'b0, "R1", "sclk in reset", 32'(sclk), 0);
    chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
    chk(res_valid === 1'b0, "R1", "valid in reset", 32'(res_valid), 0);
    chk(trail_err === 1'b0, "R1", "err in reset", 32'(trail_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3, R9: poll rounds with nothing pending
    enable = 1'b1;
    repeat (60) @(negedge clk);
    chk(n_valid == 0, "R3", "no result without ready", n_valid, 0);
    enable = 1'b0;
    wait_idle();
    chk(cs_n === '1, "R9", "idle selects", 32'(cs_n), 32'hF);

    // R4, R5: single converter, fastest clock
    sval[2] = 16'hA5C3; pend[2]++;
    half_div = 8'd0;
    enable = 1'b1;
    wait_drained();
    enable = 1'b0;
    wait_idle();
    chk(n_valid == 1, "R5", "one result", n_valid, 1);

    // R2, R4, R5: all converters, slower clock, edge patterns
    sval[0] = 16'h8001; sval[1] = 16'h7FFE; sval[2] = 16'hFFFF; sval[3] = 16'h0000;
    for (int i = 0; i < N; i++) pend[i]++;
    half_div = 8'd2;
    enable = 1'b1;
    wait_drained();
    enable = 1'b0;
    wait_idle();
    chk(n_valid == 5, "R2", "results after full rotation", n_valid, 5);

    // R7: trailer fault on converter 1
    sval[1] = 16'h1234; sfault[1] = 1'b1; pend[1]++;
    half_div = 8'd1;
    enable = 1'b1;
    wait_drained();
    enable = 1'b0;
    wait_idle();
    chk(n_err == 1, "R7", "trailer fault flagged", n_err, 1);
    sfault[1] = 1'b0;

    // R8, R9: short enable bursts
    enable = 1'b1;
    repeat (7) @(negedge clk);
    enable = 1'b0;
    wait_idle();
    chk(busy === 1'b0, "R9", "idle after burst", 32'(busy), 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule